// File: doc/BRIEF.md
# Loadable Wiper Position Counter

This block holds the six-bit tap position of a digitally set resistor divider and turns it into 64 switch enables, of which exactly one is on. The position can change in four ways: the host writes a new value, a transfer copies one of four stored setting words, single-step pulses move it one tap up or down, and after every reset the block reloads stored word 0 by itself. Command decoding and the storage of the setting words sit elsewhere. This block sees each request as a one-cycle strobe with its data, and it sees the four setting words as a flat bus.

A small state machine has two states. `ST_RECALL` is entered on reset. Its only transition, *recall done*, is taken on the first clock edge after reset is released; that edge loads word 0 and moves to `ST_TRACK`. `ST_TRACK` has one transition, *stay*, back to itself. In it the strobes are served in a fixed priority order and the position is held when no strobe is present. The switch enables are registered one cycle behind the position, so a tap change can never switch two taps on at once.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: `wiper_pos` is six bits wide. 0x00 is the low end of the divider and 0x3F the high end. `tap_en` bit k is high exactly when `wiper_pos` held k one clock earlier.
- R2: Exactly one bit of `tap_en` is high in every cycle. This includes reset, when bit 0 is high.
- R3: While `rst_n` is low, `wiper_pos` is 0x00. The first clock edge after `rst_n` rises loads word 0 (`bank_data[5:0]`), and every strobe in that cycle is ignored.
- R4: With `host_wr_stb` high, the next edge loads `host_wr_data` into `wiper_pos`.
- R5: With `xfer_stb` high, the next edge loads word `xfer_sel` (`bank_data[6*xfer_sel +: 6]`).
- R6: With `step_stb` high, the next edge adds one if `step_up` is 1 and subtracts one if `step_up` is 0.
- R7: Steps saturate. An up-step at 0x3F and a down-step at 0x00 leave the position unchanged.
- R8: When strobes coincide, a host write wins over a transfer, and a transfer wins over a step.
- R9: With no strobe high, the position holds. `step_up` has no effect unless `step_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr_stb | input | 1 | Host write request |
| host_wr_data | input | 6 | Position written by the host |
| xfer_stb | input | 1 | Transfer request from a stored word |
| xfer_sel | input | 2 | Index of the stored word to transfer |
| step_stb | input | 1 | Single-step request |
| step_up | input | 1 | Step direction, 1 up and 0 down |
| bank_data | input | 24 | Four stored six-bit words; word i sits at bits 6i+5:6i |
| wiper_pos | output | 6 | Current position |
| tap_en | output | 64 | One-hot switch enables |

## Verification
The case that matters most is a load arriving in the same cycle as a single step. This is provoked by asserting a transfer strobe or a host write strobe together with `step_stb`. A host write is also raised together with a transfer. The result is judged on the next edge: the position must equal the loaded value, with no trace of the step. The one-cycle lag of `tap_en` is checked on every such step as well, and so is its one-hot property.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    typedef enum logic [0:0] {
        ST_RECALL,
        ST_TRACK
    } wp_state_e;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_RECALL,
        SRC_HOST,
        SRC_XFER,
        SRC_UP,
        SRC_DOWN
    } wp_src_e;

endpackage

// File: rtl/wiper_src_sel.sv
// Chooses which source updates the position in this cycle.
// The saturation of steps is decided here (R7, R8).
module wiper_src_sel
    import wiper_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  logic             recall,
    input  logic             host_wr_stb,
    input  logic             xfer_stb,
    input  logic             step_stb,
    input  logic             step_up,
    input  logic [POS_W-1:0] cur_pos,
    output wp_src_e          src
);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
    localparam logic [POS_W-1:0] POS_MIN = '0;

    logic at_top;
    logic at_bot;

    assign at_top = (cur_pos == POS_MAX);
    assign at_bot = (cur_pos == POS_MIN);

    always_comb begin
        if (recall) begin
            src = SRC_RECALL;
        end else if (host_wr_stb) begin
            src = SRC_HOST;
        end else if (xfer_stb) begin
            src = SRC_XFER;
        end else if (step_stb && step_up && !at_top) begin
            src = SRC_UP;
        end else if (step_stb && !step_up && !at_bot) begin
            src = SRC_DOWN;
        end else begin
            src = SRC_HOLD;
        end
    end

endmodule

// File: rtl/wiper_next_calc.sv
// Forms the next position from the chosen source.
module wiper_next_calc
    import wiper_pkg::*;
#(
    parameter int POS_W    = 6,
    parameter int NUM_REGS = 4,
    parameter int SEL_W    = $clog2(NUM_REGS)
) (
    input  wp_src_e                     src,
    input  logic [POS_W-1:0]            cur_pos,
    input  logic [POS_W-1:0]            host_wr_data,
    input  logic [SEL_W-1:0]            xfer_sel,
    input  logic [NUM_REGS*POS_W-1:0]   bank_data,
    output logic [POS_W-1:0]            nxt_pos
);
    logic [POS_W-1:0] words [NUM_REGS];

    for (genvar w = 0; w < NUM_REGS; w++) begin : g_unpack
        assign words[w] = bank_data[w*POS_W +: POS_W];
    end

    always_comb begin
        unique case (src)
            SRC_RECALL: nxt_pos = words[0];
            SRC_HOST:   nxt_pos = host_wr_data;
            SRC_XFER:   nxt_pos = words[xfer_sel];
            SRC_UP:     nxt_pos = cur_pos + POS_W'(1);
            SRC_DOWN:   nxt_pos = cur_pos - POS_W'(1);
            default:    nxt_pos = cur_pos;
        endcase
    end

endmodule

// File: rtl/wiper_tap_decode.sv
// Registered one-hot decode of the position into switch enables (R1, R2).
module wiper_tap_decode #(
    parameter int POS_W = 6,
    parameter int TAPS  = 1 << POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos,
    output logic [TAPS-1:0]  tap_q
);
    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tap_q[g] <= (g == 0);
            end else begin
                tap_q[g] <= (pos == POS_W'(g));
            end
        end
    end

endmodule

// File: rtl/wiper_pos_ctrl.sv
module wiper_pos_ctrl
    import wiper_pkg::*;
#(
    parameter int POS_W    = 6,
    parameter int NUM_REGS = 4,
    parameter int SEL_W    = $clog2(NUM_REGS),
    parameter int TAPS     = 1 << POS_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_wr_stb,
    input  logic [POS_W-1:0]          host_wr_data,
    input  logic                      xfer_stb,
    input  logic [SEL_W-1:0]          xfer_sel,
    input  logic                      step_stb,
    input  logic                      step_up,
    input  logic [NUM_REGS*POS_W-1:0] bank_data,
    output logic [POS_W-1:0]          wiper_pos,
    output logic [TAPS-1:0]           tap_en
);
    wp_state_e        state_q;
    wp_state_e        state_d;
    wp_src_e          src;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_d;
    logic             recall;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RECALL;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: recall done, stay
    always_comb begin
        unique case (state_q)
            ST_RECALL: state_d = ST_TRACK;
            ST_TRACK:  state_d = ST_TRACK;
            default:   state_d = ST_RECALL;
        endcase
    end

    assign recall = (state_q == ST_RECALL);

    wiper_src_sel #(
        .POS_W (POS_W)
    ) u_src (
        .recall      (recall),
        .host_wr_stb (host_wr_stb),
        .xfer_stb    (xfer_stb),
        .step_stb    (step_stb),
        .step_up     (step_up),
        .cur_pos     (pos_q),
        .src         (src)
    );

    wiper_next_calc #(
        .POS_W    (POS_W),
        .NUM_REGS (NUM_REGS),
        .SEL_W    (SEL_W)
    ) u_next (
        .src          (src),
        .cur_pos      (pos_q),
        .host_wr_data (host_wr_data),
        .xfer_sel     (xfer_sel),
        .bank_data    (bank_data),
        .nxt_pos      (pos_d)
    );

    // output process: position register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    wiper_tap_decode #(
        .POS_W (POS_W),
        .TAPS  (TAPS)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .pos   (pos_q),
        .tap_q (tap_en)
    );

    assign wiper_pos = pos_q;

endmodule

// File: rtl/wiper_pos_ctrl_chk.sv
module wiper_pos_ctrl_chk #(
    parameter int POS_W    = 6,
    parameter int NUM_REGS = 4,
    parameter int SEL_W    = $clog2(NUM_REGS),
    parameter int TAPS     = 1 << POS_W
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      host_wr_stb,
    input logic [POS_W-1:0]          host_wr_data,
    input logic                      xfer_stb,
    input logic [SEL_W-1:0]          xfer_sel,
    input logic                      step_stb,
    input logic                      step_up,
    input logic [NUM_REGS*POS_W-1:0] bank_data,
    input logic [POS_W-1:0]          wiper_pos,
    input logic [TAPS-1:0]           tap_en
);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    logic             first_q;
    logic [POS_W-1:0] sel_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) first_q <= 1'b1;
        else        first_q <= 1'b0;
    end

    assign sel_word = bank_data[xfer_sel*POS_W +: POS_W];

    assert_tap_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tap_en == (TAPS'(1) << $past(wiper_pos)));

    assert_one_tap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_en) == 1);

    assert_recall_word0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |=> wiper_pos == $past(bank_data[POS_W-1:0]));

    assert_host_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_q && host_wr_stb) |=> wiper_pos == $past(host_wr_data));

    assert_xfer_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_q && xfer_stb && !host_wr_stb) |=> wiper_pos == $past(sel_word));

    assert_step_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_q && step_stb && step_up && !host_wr_stb && !xfer_stb
         && wiper_pos != POS_MAX) |=> wiper_pos == $past(wiper_pos) + POS_W'(1));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_q && step_stb && step_up && !host_wr_stb && !xfer_stb
         && wiper_pos == POS_MAX) |=> $stable(wiper_pos));

    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_q && step_stb && !step_up && !host_wr_stb && !xfer_stb
         && wiper_pos == '0) |=> $stable(wiper_pos));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_q && !step_stb && !host_wr_stb && !xfer_stb) |=> $stable(wiper_pos));

endmodule

bind wiper_pos_ctrl wiper_pos_ctrl_chk #(
    .POS_W    (POS_W),
    .NUM_REGS (NUM_REGS),
    .SEL_W    (SEL_W),
    .TAPS     (TAPS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_stb  (host_wr_stb),
    .host_wr_data (host_wr_data),
    .xfer_stb     (xfer_stb),
    .xfer_sel     (xfer_sel),
    .step_stb     (step_stb),
    .step_up      (step_up),
    .bank_data    (bank_data),
    .wiper_pos    (wiper_pos),
    .tap_en       (tap_en)
);

// File: tb/test_wiper_pos_ctrl.sv
`timescale 1ns/1ps
module test_wiper_pos_ctrl;

    typedef struct packed {
        logic       wr;
        logic [5:0] wd;
        logic       xf;
        logic [1:0] sel;
        logic       st;
        logic       up;
        logic [5:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 14;
    // stored words: w0=0x11 w1=0x3E w2=0x01 w3=0x25
    localparam logic [23:0] BANK = {6'h25, 6'h01, 6'h3E, 6'h11};

    localparam vec_t VECS [NV] = '{
        '{1'b1, 6'h3E, 1'b0, 2'd0, 1'b0, 1'b0, 6'h3E, 4'd4}, // R4 host write
        '{1'b0, 6'h00, 1'b0, 2'd0, 1'b1, 1'b1, 6'h3F, 4'd6}, // R6 up
        '{1'b0, 6'h00, 1'b0, 2'd0, 1'b1, 1'b1, 6'h3F, 4'd7}, // R7 top saturate
        '{1'b0, 6'h00, 1'b1, 2'd2, 1'b0, 1'b0, 6'h01, 4'd5}, // R5 transfer w2
        '{1'b0, 6'h00, 1'b0, 2'd0, 1'b1, 1'b0, 6'h00, 4'd6}, // R6 down
        '{1'b0, 6'h00, 1'b0, 2'd0, 1'b1, 1'b0, 6'h00, 4'd7}, // R7 bottom saturate
        '{1'b0, 6'h00, 1'b0, 2'd0, 1'b1, 1'b1, 6'h01, 4'd6}, // R6 up from bottom
        '{1'b0, 6'h00, 1'b1, 2'd3, 1'b1, 1'b1, 6'h25, 4'd8}, // R8 transfer beats step
        '{1'b1, 6'h07, 1'b1, 2'd1, 1'b0, 1'b0, 6'h07, 4'd8}, // R8 host beats transfer
        '{1'b1, 6'h20, 1'b0, 2'd0, 1'b1, 1'b0, 6'h20, 4'd8}, // R8 host beats step
        '{1'b0, 6'h00, 1'b0, 2'd0, 1'b0, 1'b0, 6'h20, 4'd9}, // R9 idle
        '{1'b0, 6'h00, 1'b1, 2'd0, 1'b0, 1'b0, 6'h11, 4'd5}, // R5 transfer w0
        '{1'b0, 6'h00, 1'b0, 2'd0, 1'b0, 1'b1, 6'h11, 4'd9}, // R9 direction alone
        '{1'b0, 6'h00, 1'b0, 2'd0, 1'b1, 1'b0, 6'h10, 4'd6}  // R6 down
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr_stb;
    logic [5:0]  host_wr_data;
    logic        xfer_stb;
    logic [1:0]  xfer_sel;
    logic        step_stb;
    logic        step_up;
    logic [23:0] bank_data;
    logic [5:0]  wiper_pos;
    logic [63:0] tap_en;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    wiper_pos_ctrl i_wiper_pos_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_stb  (host_wr_stb),
        .host_wr_data (host_wr_data),
        .xfer_stb     (xfer_stb),
        .xfer_sel     (xfer_sel),
        .step_stb     (step_stb),
        .step_up      (step_up),
        .bank_data    (bank_data),
        .wiper_pos    (wiper_pos),
        .tap_en       (tap_en)
    );

    task automatic chk(input int req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic idle_in();
        host_wr_stb  = 1'b0;
        host_wr_data = '0;
        xfer_stb     = 1'b0;
        xfer_sel     = '0;
        step_stb     = 1'b0;
        step_up      = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [5:0] prev;
        bank_data = BANK;
        rst_n     = 1'b0;
        idle_in();
        repeat (3) @(negedge clk);
        chk(3, 64'(wiper_pos), 64'h0);              // R3 reset value
        chk(2, tap_en, 64'h1);                      // R2 reset tap

        // release with a host write pending: ignored during recall (R3)
        host_wr_stb  = 1'b1;
        host_wr_data = 6'h05;
        rst_n        = 1'b1;
        @(negedge clk);
        idle_in();
        chk(3, 64'(wiper_pos), 64'h11);             // R3 recall word 0
        chk(1, tap_en, 64'h1);                      // R1 decode lags one cycle
        prev = 6'h11;

        for (int i = 0; i < NV; i++) begin
            host_wr_stb  = VECS[i].wr;
            host_wr_data = VECS[i].wd;
            xfer_stb     = VECS[i].xf;
            xfer_sel     = VECS[i].sel;
            step_stb     = VECS[i].st;
            step_up      = VECS[i].up;
            @(negedge clk);
            chk(int'(VECS[i].req), 64'(wiper_pos), 64'(VECS[i].exp));
            chk(1, tap_en, 64'h1 << prev);          // R1
            chk(2, 64'($countones(tap_en)), 64'd1); // R2
            prev = VECS[i].exp;
        end
        idle_in();
        @(negedge clk);
        chk(1, tap_en, 64'h1 << prev);              // R1 final tap
        chk(9, 64'(wiper_pos), 64'(prev));          // R9 hold

        // asynchronous reset in mid-run, then recall again (R3)
        rst_n = 1'b0;
        @(negedge clk);
        chk(3, 64'(wiper_pos), 64'h0);
        chk(2, tap_en, 64'h1);
        rst_n    = 1'b1;
        xfer_stb = 1'b1;
        xfer_sel = 2'd1;
        @(negedge clk);
        idle_in();
        chk(3, 64'(wiper_pos), 64'h11);             // R3 transfer ignored during recall
        @(negedge clk);
        chk(1, tap_en, 64'h1 << 17);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule